// File: doc/BRIEF.md
# Dual-Target Boot-Entry Sequencer

This block sits between the modem-control outputs of a shared USB-to-UART bridge and two target processors. Each target has two incoming control lines: one acts as a boot request and the other as a reset request. When the lines of one target go through a fixed three-edge pattern, the block produces that target's boot-entry waveform. The boot strap is pulled low, the reset line is pulsed low while the strap is held, and then both lines are released. The two targets use different pulse timings.

All input activity is ignored for a blanking window after reset, so glitches while the bridge starts up cannot trigger a sequence. After a sequence starts on one target, the other target is locked out. A recovery timeout, restarted by every recognised edge and by the end of a waveform, returns the block to its armed state. An edge that breaks the pattern stops all input watching until that timeout runs out. A static option swaps which pin of each pair is the boot request. Every delay is a parameter counted in clock cycles.

Top module: `boot_entry_seq`

## Requirements
- R1: During the first BLANK_CYC cycles after reset, every input edge is ignored. A complete sequence driven inside this window produces no waveform.
- R2: During reset and after reset, both boot outputs are 1, both reset drive enables are 0 and both reset output values are 1.
- R3: A falling edge on a target's boot-request pin, then a falling edge and then a rising edge on the same target's reset-request pin, starts that target's waveform and no other. Reset-request edges that arrive without a preceding boot-request fall are ignored.
- R4: The target A waveform holds the boot output at 0 with reset driven 1 for A_PRE_CYC cycles. Reset is then driven 0 for A_PULSE_CYC cycles, and then driven 1 for A_POST_CYC cycles. After that the boot output returns to 1 and the drive enable to 0.
- R5: The target B waveform has the same shape as target A, with the lengths B_PRE_CYC, B_PULSE_CYC and B_POST_CYC.
- R6: After a boot-request fall on one target, the other target's inputs are ignored until the timeout clears the state.
- R7: If TIMEOUT_CYC cycles pass with no recognised edge, all sequence state is cleared. A later reset-request fall and rise then does nothing until a new boot-request fall arrives.
- R8: A reset-request rising edge that arrives while a reset-request fall is awaited disables all input watching on both targets until the timeout expires. After the timeout, a full sequence works again.
- R9: With swap_roles = 0, line0 of each pair is the boot request and line1 is the reset request. With swap_roles = 1 the two roles are exchanged.
- R10: The reset drive enable is 1 only while a waveform is running. Whenever it is 0, the reset output value is 1. A boot output is 0 exactly when its reset drive enable is 1.
- R11: Input edges are ignored while a waveform runs. The timeout restarts when the waveform completes, so a new sequence is ignored until TIMEOUT_CYC cycles after completion.
- R12: If both targets see a boot-request fall in the same cycle, target A is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| swap_roles | input | 1 | 0: line0 is the boot request; 1: line1 is the boot request (static) |
| a_line0 | input | 1 | Target A control line 0 (asynchronous, idles high) |
| a_line1 | input | 1 | Target A control line 1 (asynchronous, idles high) |
| b_line0 | input | 1 | Target B control line 0 (asynchronous, idles high) |
| b_line1 | input | 1 | Target B control line 1 (asynchronous, idles high) |
| a_boot_n | output | 1 | Target A boot strap, active low |
| a_rst_out | output | 1 | Target A reset output value |
| a_rst_oe | output | 1 | Target A reset drive enable (0 = high impedance) |
| b_boot_n | output | 1 | Target B boot strap, active low |
| b_rst_out | output | 1 | Target B reset output value |
| b_rst_oe | output | 1 | Target B reset drive enable (0 = high impedance) |

## Verification
The assertions check the output relations that must hold on every cycle. Reset is never driven low while undriven, the boot strap follows the drive enable, the two targets are never driven at once, and each waveform starts and ends with reset high while reset is still driven. They also check the output state right after reset. Only the bench scenarios can show the sequence-dependent behaviour. This covers blanking, the exact segment lengths per target, lockout of the other target, the timeout clearing partial sequences, the dead state after an unfit edge, the hold-off after a waveform, role swapping and the tie between targets.

// File: rtl/bes_pkg.sv
// Package: shared types for the dual-target boot-entry sequencer.
// Assumes: two targets, indexed 0 (A) and 1 (B).
package bes_pkg;

    localparam int NUM_TGT = 2;

    // Sequencer states
    typedef enum logic [2:0] {
        SQ_BLANK,   // power-up blanking, inputs ignored
        SQ_IDLE,    // armed: watching boot-request falls on both targets
        SQ_BOOT,    // boot request seen, awaiting reset-request fall
        SQ_RLOW,    // reset request low, awaiting its rise
        SQ_FIRE,    // waveform running on the selected target
        SQ_HOLD     // inputs ignored until timeout expires
    } sq_state_t;

    // Waveform phases
    typedef enum logic [1:0] {
        WV_IDLE,
        WV_PRE,
        WV_PULSE,
        WV_POST
    } wv_phase_t;

    // Per-target decoded edge events after role mapping
    typedef struct packed {
        logic boot_fall;
        logic rst_fall;
        logic rst_rise;
    } tgt_ev_t;

endpackage

// File: rtl/bes_sync.sv
// Module: bes_sync
// Two-flop synchroniser followed by an edge detector. Each transition of
// the asynchronous input yields exactly one single-cycle rise or fall pulse.
// Assumes: the input idles at IDLE_VAL, which is also the reset value, so
// that releasing reset creates no event.
module bes_sync #(
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Synchronise the input and keep one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= IDLE_VAL;
            sync_q <= IDLE_VAL;
            prev_q <= IDLE_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Single-cycle edge pulses from the synchronised level
    always_comb begin
        rise = sync_q & ~prev_q;
        fall = ~sync_q & prev_q;
    end

endmodule

// File: rtl/bes_seq.sv
// Module: bes_seq
// Sequence decoder and arbiter. After the blanking window it waits for a
// boot-request fall on either target (A wins a tie), locks onto that target,
// then expects a reset-request fall and rise. A rise arriving first sends
// the block to a hold state. A recognised edge or the end of a waveform
// reloads the recovery timeout; expiry returns to the armed state.
// Assumes: BLANK_CYC >= 1 and TIMEOUT_CYC >= 1.
module bes_seq
    import bes_pkg::*;
#(
    parameter int unsigned BLANK_CYC   = 100_000_000,
    parameter int unsigned TIMEOUT_CYC = 10_000_000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  tgt_ev_t [NUM_TGT-1:0]  ev,
    input  logic    [NUM_TGT-1:0]  wave_done,
    output logic    [NUM_TGT-1:0]  fire
);

    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [BW-1:0] BLANK_LAST = BW'(BLANK_CYC - 1);
    localparam logic [TW-1:0] TMO_LOAD   = TW'(TIMEOUT_CYC - 1);

    sq_state_t     state_q, state_d;
    logic          sel_q, sel_d;
    logic [BW-1:0] blank_q;
    logic [TW-1:0] tmo_q;
    logic          restart;
    logic          tmo_hit;
    tgt_ev_t       ev_sel;

    // Events of the locked target and timeout expiry flag
    always_comb begin
        ev_sel  = ev[sel_q];
        tmo_hit = (tmo_q == '0);
    end

    // Next-state, target selection, timeout restart and fire decode
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        restart = 1'b0;
        fire    = '0;
        case (state_q)
            SQ_BLANK: begin
                if (blank_q == BLANK_LAST) state_d = SQ_IDLE;
            end
            SQ_IDLE: begin
                if (ev[0].boot_fall) begin
                    state_d = SQ_BOOT;
                    sel_d   = 1'b0;
                    restart = 1'b1;
                end else if (ev[1].boot_fall) begin
                    state_d = SQ_BOOT;
                    sel_d   = 1'b1;
                    restart = 1'b1;
                end
            end
            SQ_BOOT: begin
                if (ev_sel.rst_fall) begin
                    state_d = SQ_RLOW;
                    restart = 1'b1;
                end else if (ev_sel.rst_rise) begin
                    state_d = SQ_HOLD;
                    restart = 1'b1;
                end else if (tmo_hit) begin
                    state_d = SQ_IDLE;
                end
            end
            SQ_RLOW: begin
                if (ev_sel.rst_rise) begin
                    state_d    = SQ_FIRE;
                    fire[sel_q] = 1'b1;
                end else if (tmo_hit) begin
                    state_d = SQ_IDLE;
                end
            end
            SQ_FIRE: begin
                if (wave_done[sel_q]) begin
                    state_d = SQ_HOLD;
                    restart = 1'b1;
                end
            end
            SQ_HOLD: begin
                if (tmo_hit) state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State and selected-target registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_BLANK;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // Blanking counter, runs only in the blanking state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_q <= '0;
        end else if (state_q == SQ_BLANK && blank_q != BLANK_LAST) begin
            blank_q <= blank_q + 1'b1;
        end
    end

    // Recovery timeout: reload on restart, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q <= TMO_LOAD;
        end else if (restart) begin
            tmo_q <= TMO_LOAD;
        end else if (tmo_q != '0) begin
            tmo_q <= tmo_q - 1'b1;
        end
    end

endmodule

// File: rtl/bes_wave.sv
// Module: bes_wave
// Boot-entry waveform generator for one target. A start pulse begins a
// three-phase run: strap low with reset driven high (PRE), reset driven low
// (PULSE), reset driven high (POST). The run then ends with the strap
// released and reset undriven. done pulses in the final cycle of POST.
// Assumes: every phase length is at least one cycle; start is ignored
// while a run is in progress.
module bes_wave
    import bes_pkg::*;
#(
    parameter int unsigned PRE_CYC   = 200_000,
    parameter int unsigned PULSE_CYC = 200_000,
    parameter int unsigned POST_CYC  = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done,
    output logic boot_n,
    output logic rst_out,
    output logic rst_oe
);

    localparam int unsigned MAX_AB  = (PRE_CYC > PULSE_CYC) ? PRE_CYC : PULSE_CYC;
    localparam int unsigned MAX_CYC = (MAX_AB > POST_CYC) ? MAX_AB : POST_CYC;
    localparam int CW = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] PRE_LOAD   = CW'(PRE_CYC - 1);
    localparam logic [CW-1:0] PULSE_LOAD = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] POST_LOAD  = CW'(POST_CYC - 1);

    wv_phase_t     phase_q;
    logic [CW-1:0] cnt_q;

    // Phase sequencing with a per-phase down counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= WV_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                WV_IDLE: begin
                    if (start) begin
                        phase_q <= WV_PRE;
                        cnt_q   <= PRE_LOAD;
                    end
                end
                WV_PRE: begin
                    if (cnt_q == '0) begin
                        phase_q <= WV_PULSE;
                        cnt_q   <= PULSE_LOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                WV_PULSE: begin
                    if (cnt_q == '0) begin
                        phase_q <= WV_POST;
                        cnt_q   <= POST_LOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                WV_POST: begin
                    if (cnt_q == '0) begin
                        phase_q <= WV_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= WV_IDLE;
            endcase
        end
    end

    // Output decode from the phase register
    always_comb begin
        boot_n  = (phase_q == WV_IDLE);
        rst_oe  = (phase_q != WV_IDLE);
        rst_out = (phase_q != WV_PULSE);
        done    = (phase_q == WV_POST) && (cnt_q == '0);
    end

endmodule

// File: rtl/boot_entry_seq.sv
// Module: boot_entry_seq (top)
// Dual-target boot-entry sequencer. It synchronises the four control lines,
// maps them to boot/reset roles per the swap option, decodes the sequence
// and drives one waveform generator per target with its own timing.
// Assumes: control lines idle high; swap_roles is changed only while idle.
module boot_entry_seq
    import bes_pkg::*;
#(
    parameter int unsigned BLANK_CYC   = 100_000_000,
    parameter int unsigned TIMEOUT_CYC = 10_000_000,
    parameter int unsigned A_PRE_CYC   = 200_000,
    parameter int unsigned A_PULSE_CYC = 200_000,
    parameter int unsigned A_POST_CYC  = 2_000_000,
    parameter int unsigned B_PRE_CYC   = 20_000,
    parameter int unsigned B_PULSE_CYC = 200_000,
    parameter int unsigned B_POST_CYC  = 400_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_roles,
    input  logic a_line0,
    input  logic a_line1,
    input  logic b_line0,
    input  logic b_line1,
    output logic a_boot_n,
    output logic a_rst_out,
    output logic a_rst_oe,
    output logic b_boot_n,
    output logic b_rst_out,
    output logic b_rst_oe
);

    localparam int NUM_LINES = 2 * NUM_TGT;

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] line_rise;
    logic [NUM_LINES-1:0] line_fall;
    tgt_ev_t [NUM_TGT-1:0] tgt_ev;
    logic [NUM_TGT-1:0]   fire;
    logic [NUM_TGT-1:0]   wave_done;
    logic [NUM_TGT-1:0]   boot_n_v;
    logic [NUM_TGT-1:0]   rst_out_v;
    logic [NUM_TGT-1:0]   rst_oe_v;

    // Gather raw lines: index 2*t + k is line k of target t
    always_comb begin
        raw_lines = {b_line1, b_line0, a_line1, a_line0};
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_sync
        bes_sync #(.IDLE_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[i]),
            .rise (line_rise[i]),
            .fall (line_fall[i])
        );
    end

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        localparam int unsigned PRE   = (t == 0) ? A_PRE_CYC   : B_PRE_CYC;
        localparam int unsigned PULSE = (t == 0) ? A_PULSE_CYC : B_PULSE_CYC;
        localparam int unsigned POST  = (t == 0) ? A_POST_CYC  : B_POST_CYC;

        // Map line events to boot/reset roles under the swap option
        always_comb begin
            tgt_ev[t].boot_fall = swap_roles ? line_fall[2*t+1] : line_fall[2*t];
            tgt_ev[t].rst_fall  = swap_roles ? line_fall[2*t]   : line_fall[2*t+1];
            tgt_ev[t].rst_rise  = swap_roles ? line_rise[2*t]   : line_rise[2*t+1];
        end

        bes_wave #(
            .PRE_CYC  (PRE),
            .PULSE_CYC(PULSE),
            .POST_CYC (POST)
        ) u_wave (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (fire[t]),
            .done   (wave_done[t]),
            .boot_n (boot_n_v[t]),
            .rst_out(rst_out_v[t]),
            .rst_oe (rst_oe_v[t])
        );
    end

    bes_seq #(
        .BLANK_CYC  (BLANK_CYC),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (tgt_ev),
        .wave_done(wave_done),
        .fire     (fire)
    );

    // Drive the per-target pins
    always_comb begin
        a_boot_n  = boot_n_v[0];
        a_rst_out = rst_out_v[0];
        a_rst_oe  = rst_oe_v[0];
        b_boot_n  = boot_n_v[1];
        b_rst_out = rst_out_v[1];
        b_rst_oe  = rst_oe_v[1];
    end

endmodule

// File: rtl/bes_chk.sv
// Module: bes_chk
// Property checker for boot_entry_seq, attached by bind. It checks the
// per-cycle relations between the output pins of both targets.
module bes_chk (
    input logic clk,
    input logic rst_n,
    input logic a_boot_n,
    input logic a_rst_out,
    input logic a_rst_oe,
    input logic b_boot_n,
    input logic b_rst_out,
    input logic b_rst_oe
);

    // R2
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (a_boot_n && b_boot_n && !a_rst_oe && !b_rst_oe));

    // R10
    a_undriven_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_rst_oe |-> a_rst_out);

    // R10
    b_undriven_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_rst_oe |-> b_rst_out);

    // R10
    a_strap_follows_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_rst_oe == !a_boot_n);

    // R10
    b_strap_follows_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_rst_oe == !b_boot_n);

    // R6
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_rst_oe && b_rst_oe));

    // R4
    a_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_rst_oe) |-> a_rst_out);

    // R5
    b_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_rst_oe) |-> b_rst_out);

    // R4
    a_end_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_rst_oe) |-> $past(a_rst_out));

    // R5
    b_end_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_rst_oe) |-> $past(b_rst_out));

endmodule

bind boot_entry_seq bes_chk u_bes_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_boot_n (a_boot_n),
    .a_rst_out(a_rst_out),
    .a_rst_oe (a_rst_oe),
    .b_boot_n (b_boot_n),
    .b_rst_out(b_rst_out),
    .b_rst_oe (b_rst_oe)
);

// File: tb/boot_entry_seq_bench.sv
`timescale 1ns/1ps
module boot_entry_seq_bench;

    localparam int BLANK = 40;
    localparam int TMO   = 200;
    localparam int A_PRE = 10, A_PUL = 12, A_POST = 30;
    localparam int B_PRE = 3,  B_PUL = 8,  B_POST = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic swap_roles = 1'b0;
    logic [3:0] lines = 4'hF;
    logic a_boot_n, a_rst_out, a_rst_oe, b_boot_n, b_rst_out, b_rst_oe;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    boot_entry_seq #(
        .BLANK_CYC(BLANK), .TIMEOUT_CYC(TMO),
        .A_PRE_CYC(A_PRE), .A_PULSE_CYC(A_PUL), .A_POST_CYC(A_POST),
        .B_PRE_CYC(B_PRE), .B_PULSE_CYC(B_PUL), .B_POST_CYC(B_POST)
    ) u_boot_entry_seq (
        .clk(clk), .rst_n(rst_n), .swap_roles(swap_roles),
        .a_line0(lines[0]), .a_line1(lines[1]),
        .b_line0(lines[2]), .b_line1(lines[3]),
        .a_boot_n(a_boot_n), .a_rst_out(a_rst_out), .a_rst_oe(a_rst_oe),
        .b_boot_n(b_boot_n), .b_rst_out(b_rst_out), .b_rst_oe(b_rst_oe)
    );

    // Vector: [3] target (0=A,1=B), [2] swap, [1] drive boot fall, [0] expect fire
    localparam logic [3:0] VEC [6] = '{
        4'b0011, 4'b1011, 4'b0111, 4'b1111, 4'b0000, 4'b1100
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Boot-request pin index is 2*t + swap; reset-request is 2*t + !swap
    task automatic drive_boot(input int t, input logic v);
        lines[2*t + (swap_roles ? 1 : 0)] = v;
    endtask

    task automatic drive_rst(input int t, input logic v);
        lines[2*t + (swap_roles ? 0 : 1)] = v;
    endtask

    task automatic full_seq(input int t, input bit with_boot);
        if (with_boot) drive_boot(t, 1'b0);
        wait_n(4);
        drive_rst(t, 1'b0);
        wait_n(4);
        drive_rst(t, 1'b1);
        drive_boot(t, 1'b1);
    endtask

    function automatic logic oe_of(input int t);
        return (t == 0) ? a_rst_oe : b_rst_oe;
    endfunction

    function automatic logic ro_of(input int t);
        return (t == 0) ? a_rst_out : b_rst_out;
    endfunction

    function automatic logic bn_of(input int t);
        return (t == 0) ? a_boot_n : b_boot_n;
    endfunction

    // Wait for a waveform, then measure its segments and check the other target
    task automatic watch_fire(input int tgt, input bit exp, input string tag);
        int got = -1;
        int n1 = 0, n2 = 0, n3 = 0;
        bit other_busy = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!a_boot_n) begin got = 0; break; end
            if (!b_boot_n) begin got = 1; break; end
        end
        if (!exp) begin
            check(got == -1, tag, got, -1);
            return;
        end
        check(got == tgt, tag, got, tgt);
        if (got < 0) return;
        while (oe_of(got) && ro_of(got) && n1 < 1000) begin
            n1++; other_busy |= oe_of(1 - got); @(negedge clk);
        end
        while (oe_of(got) && !ro_of(got) && n2 < 1000) begin
            n2++; other_busy |= oe_of(1 - got); @(negedge clk);
        end
        while (oe_of(got) && ro_of(got) && n3 < 1000) begin
            n3++; other_busy |= oe_of(1 - got); @(negedge clk);
        end
        if (got == 0) begin
            check(n1 == A_PRE,  "R4 pre",   n1, A_PRE);
            check(n2 == A_PUL,  "R4 pulse", n2, A_PUL);
            check(n3 == A_POST, "R4 post",  n3, A_POST);
        end else begin
            check(n1 == B_PRE,  "R5 pre",   n1, B_PRE);
            check(n2 == B_PUL,  "R5 pulse", n2, B_PUL);
            check(n3 == B_POST, "R5 post",  n3, B_POST);
        end
        check(!other_busy, "R6 other target idle", int'(other_busy), 0);
        check(bn_of(got) && !oe_of(got) && ro_of(got), "R10 released",
              {bn_of(got), oe_of(got), ro_of(got)}, 3'b101);
    endtask

    initial begin
        wait_n(3);
        // R2 during reset
        check(a_boot_n && b_boot_n, "R2 boot high in reset", {a_boot_n, b_boot_n}, 3);
        check(!a_rst_oe && !b_rst_oe && a_rst_out && b_rst_out, "R2 reset undriven",
              {a_rst_oe, b_rst_oe, a_rst_out, b_rst_out}, 4'b0011);
        rst_n = 1'b1;
        wait_n(1);
        check(a_boot_n && b_boot_n && !a_rst_oe && !b_rst_oe, "R2 after reset",
              {a_boot_n, b_boot_n, a_rst_oe, b_rst_oe}, 4'b1100);

        // R1: full sequence inside the blanking window
        full_seq(0, 1'b1);
        watch_fire(0, 1'b0, "R1 blanking");
        wait_n(20);

        // Vector table: R3 / R9 and ignored reset-only toggles
        for (int i = 0; i < 6; i++) begin
            int t;
            t = int'(VEC[i][3]);
            swap_roles = VEC[i][2];
            wait_n(2);
            full_seq(t, VEC[i][1]);
            watch_fire(t, VEC[i][0], VEC[i][2] ? "R9 swapped roles" : "R3 sequence");
            wait_n(TMO + 20);
        end
        swap_roles = 1'b0;
        wait_n(2);

        // R6: A locks, B sequence ignored, A completes
        drive_boot(0, 1'b0);
        wait_n(4);
        full_seq(1, 1'b1);
        watch_fire(1, 1'b0, "R6 lockout of B");
        drive_rst(0, 1'b0);
        wait_n(4);
        drive_rst(0, 1'b1);
        drive_boot(0, 1'b1);
        watch_fire(0, 1'b1, "R6 locked target fires");
        wait_n(TMO + 20);

        // R7: timeout clears a partial sequence
        drive_boot(0, 1'b0);
        wait_n(TMO + 20);
        drive_rst(0, 1'b0);
        wait_n(4);
        drive_rst(0, 1'b1);
        watch_fire(0, 1'b0, "R7 cleared by timeout");
        drive_boot(0, 1'b1);
        wait_n(TMO + 20);

        // R8: unfit edge disables watching until timeout
        drive_rst(0, 1'b0);
        wait_n(4);
        drive_boot(0, 1'b0);
        wait_n(4);
        drive_rst(0, 1'b1);
        wait_n(4);
        full_seq(0, 1'b0);
        watch_fire(0, 1'b0, "R8 dead after unfit edge");
        drive_boot(0, 1'b1);
        full_seq(1, 1'b1);
        watch_fire(1, 1'b0, "R8 other target also dead");
        wait_n(TMO + 20);
        full_seq(0, 1'b1);
        watch_fire(0, 1'b1, "R8 recovers after timeout");

        // R11: hold-off after waveform completion
        full_seq(1, 1'b1);
        watch_fire(1, 1'b0, "R11 ignored after waveform");
        wait_n(TMO + 20);
        full_seq(1, 1'b1);
        watch_fire(1, 1'b1, "R11 accepted after timeout");
        wait_n(TMO + 20);

        // R12: simultaneous boot falls, A wins
        drive_boot(0, 1'b0);
        drive_boot(1, 1'b0);
        wait_n(4);
        drive_rst(0, 1'b0);
        drive_rst(1, 1'b0);
        wait_n(4);
        drive_rst(0, 1'b1);
        drive_rst(1, 1'b1);
        drive_boot(0, 1'b1);
        drive_boot(1, 1'b1);
        watch_fire(0, 1'b1, "R12 tie goes to A");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule